// File: doc/BRIEF.md
# Effective Address Stage

This block is the second stage of a five-stage pipeline for a one-and-a-half-address machine. Each cycle it takes a fetched 32-bit instruction word and the pc that fetched it. From these it forms a 32-bit effective address, which is the sign-extended 16-bit displacement added to a base value. The 4-bit x field of the instruction picks the base. A value of zero means the base is zero. A value of fifteen means the base is the accompanying pc, which gives pc-relative addressing. Any other value names a general register, and the block reads that register through one read port of the register file.

The port is costly to cycle, so the block raises a request strobe only when it actually needs a register value. The register file answers combinationally in the same cycle. The opcode, the r field and the computed address are captured in an output pipeline register for the operand-fetch stage. The x field, the displacement and the pc end here.

Top module: `agen_stage`

## Requirements
- R1: The instruction word is split as opcode = bits 31:24, r = bits 23:20, x = bits 19:16 and displacement = bits 15:0.
- R2: When x is 0, the registered address equals the sign-extended displacement, and the read request is low.
- R3: When x is 15, the registered address equals the incoming pc plus the sign-extended displacement, and the read request is low.
- R4: For x from 1 to 14, the read request is high in the same cycle, and the registered address equals the returned register data plus the sign-extended displacement.
- R5: The register-number output always equals x, whatever the state of the request strobe.
- R6: The opcode and the r field appear on the outputs one clock after they are presented, unchanged.
- R7: When the active-low reset is sampled low at a rising edge, the opcode, r and address outputs become all zeros at that edge.
- R8: The displacement is treated as a signed two's-complement value, so a displacement of 0x8000 subtracts 32768. The 32-bit sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_instr | input | 32 | Fetched instruction word |
| in_pc | input | 32 | Pc that fetched the instruction |
| rf_rd_idx | output | 4 | Register number for the read port (always x) |
| rf_rd_req | output | 1 | Read port needed this cycle |
| rf_rd_data | input | 32 | Register value returned combinationally |
| out_opcode | output | 8 | Registered opcode |
| out_rsel | output | 4 | Registered r field |
| out_addr | output | 32 | Registered effective address |

## Verification
The strobe and the register number are combinational, so a wrong x decode shows on rf_rd_req or rf_rd_idx within the same cycle. A wrong base choice, a missing sign extension or a lost carry shows on out_addr one clock later. The stimulus therefore pairs each x class with displacements at both sign extremes, and with pc and register values that force a wrap, so that every such fault changes the registered address. Field misplacement shows one clock later on out_opcode or out_rsel. A faulty reset shows as non-zero outputs at the first edge sampled in reset.

// File: rtl/agen_pkg.sv
// Package: shared widths and field layout for the effective address stage.
// Assumes a 32-bit word, 16 general registers and a single fixed instruction format.
package agen_pkg;
    parameter int DATA_W = 32;
    parameter int OP_W   = 8;
    parameter int IDX_W  = 4;
    parameter int DISP_W = 16;

    localparam int INSTR_W = OP_W + 2 * IDX_W + DISP_W;
    localparam logic [IDX_W-1:0] X_NONE  = '0;
    localparam logic [IDX_W-1:0] X_PCREL = '1;

    typedef struct packed {
        logic [OP_W-1:0]   opcode;
        logic [IDX_W-1:0]  rsel;
        logic [IDX_W-1:0]  xsel;
        logic [DISP_W-1:0] disp;
    } instr_t;

    typedef struct packed {
        logic [OP_W-1:0]   opcode;
        logic [IDX_W-1:0]  rsel;
        logic [DATA_W-1:0] addr;
    } stage_out_t;
endpackage

// File: rtl/agen_base_sel.sv
// Base selector: decodes the x field and picks zero, the pc or register data.
// Assumes the register file returns data combinationally for the index shown.
module agen_base_sel
    import agen_pkg::*;
(
    input  logic [IDX_W-1:0]  xsel,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] rf_data,
    output logic [IDX_W-1:0]  rf_idx,
    output logic              rf_req,
    output logic [DATA_W-1:0] base
);
    logic is_none;
    logic is_pcrel;

    // Decode the two reserved x values.
    always_comb begin
        is_none  = (xsel == X_NONE);
        is_pcrel = (xsel == X_PCREL);
    end

    // Drive the read port: the index is always x, and the request is asserted
    // only when neither reserved value is present.
    always_comb begin
        rf_idx = xsel;
        rf_req = ~(is_none | is_pcrel);
    end

    // Select the base value.
    always_comb begin
        if (is_none)       base = '0;
        else if (is_pcrel) base = pc;
        else               base = rf_data;
    end
endmodule

// File: rtl/agen_disp_add.sv
// Displacement adder: sign-extends the displacement and adds it to the base.
// Assumes wrap-around arithmetic; the carry out is discarded.
module agen_disp_add
    import agen_pkg::*;
(
    input  logic [DATA_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [DATA_W-1:0] sum
);
    localparam int EXT_W = DATA_W - DISP_W;

    logic [DATA_W-1:0] disp_ext;

    // Replicate the sign bit to the full width.
    always_comb disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

    // Form the modulo-2^DATA_W sum.
    always_comb sum = base + disp_ext;
endmodule

// File: rtl/agen_stage.sv
// Effective address stage: splits the instruction, selects the base, adds the
// displacement and registers opcode, r and the address every clock.
// Assumes a synchronous active-low reset and a combinational register read port.
module agen_stage
    import agen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       in_instr,
    input  logic [31:0]       in_pc,
    output logic [3:0]        rf_rd_idx,
    output logic              rf_rd_req,
    input  logic [31:0]       rf_rd_data,
    output logic [7:0]        out_opcode,
    output logic [3:0]        out_rsel,
    output logic [31:0]       out_addr
);
    instr_t            ir;
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] ea;
    stage_out_t        q;

    // View the raw word through the field layout.
    always_comb ir = instr_t'(in_instr);

    agen_base_sel u_base (
        .xsel    (ir.xsel),
        .pc      (in_pc),
        .rf_data (rf_rd_data),
        .rf_idx  (rf_rd_idx),
        .rf_req  (rf_rd_req),
        .base    (base)
    );

    agen_disp_add u_add (
        .base (base),
        .disp (ir.disp),
        .sum  (ea)
    );

    // Output pipeline register: loads every clock and clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= '{opcode: ir.opcode, rsel: ir.rsel, addr: ea};
    end

    // Drive the output ports from the register.
    always_comb begin
        out_opcode = q.opcode;
        out_rsel   = q.rsel;
        out_addr   = q.addr;
    end
endmodule

// File: rtl/agen_stage_chk.sv
// Checker for the effective address stage, attached to it by a bind statement.
// Assumes clocked sampling on the rising edge, with reset disabling every property.
module agen_stage_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] in_instr,
    input logic [31:0] in_pc,
    input logic [3:0]  rf_rd_idx,
    input logic        rf_rd_req,
    input logic [31:0] rf_rd_data,
    input logic [7:0]  out_opcode,
    input logic [3:0]  out_rsel,
    input logic [31:0] out_addr
);
    logic [3:0]  cx;
    logic [31:0] cdisp;

    // Local views of the x field and of the sign-extended displacement.
    always_comb begin
        cx    = in_instr[19:16];
        cdisp = {{16{in_instr[15]}}, in_instr[15:0]};
    end

    p_zero_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cx == 4'd0) |-> !rf_rd_req);
    p_zero_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cx == 4'd0) |=> (out_addr == $past(cdisp)));
    p_pc_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cx == 4'd15) |-> !rf_rd_req);
    p_pc_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cx == 4'd15) |=> (out_addr == $past(in_pc + cdisp)));
    p_reg_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cx != 4'd0 && cx != 4'd15) |-> rf_rd_req);
    p_reg_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cx != 4'd0 && cx != 4'd15) |=> (out_addr == $past(rf_rd_data + cdisp)));
    p_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_idx == in_instr[19:16]);
    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_opcode == $past(in_instr[31:24]) && out_rsel == $past(in_instr[23:20])));
endmodule

bind agen_stage agen_stage_chk u_chk (.*);

// File: tb/agen_stage_tb_top.sv
// Bench for the effective address stage: a vector table followed by directed tests.
// The register-file model returns register i as i << 12.
module agen_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_pc = '0;
    logic [3:0]  rf_rd_idx;
    logic        rf_rd_req;
    logic [31:0] rf_rd_data;
    logic [7:0]  out_opcode;
    logic [3:0]  out_rsel;
    logic [31:0] out_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // Register-file model.
    always_comb rf_rd_data = {16'h0, rf_rd_idx, 12'h0};

    agen_stage dut_i (.*);

    // Each vector: instr, pc, expected address, expected request.
    localparam int NV = 8;
    localparam logic [96:0] VEC [NV] = '{
        {32'h1230_0010, 32'h0000_0100, 32'h0000_0010, 1'b0},
        {32'hA5F0_FFFF, 32'h0000_0005, 32'hFFFF_FFFF, 1'b0},
        {32'h017F_0004, 32'h0000_1000, 32'h0000_1004, 1'b0},
        {32'hFF0F_FFFE, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0},
        {32'h3C41_0020, 32'h0000_0000, 32'h0000_1020, 1'b1},
        {32'h77EE_8000, 32'h1234_5678, 32'h0000_6000, 1'b1},
        {32'h0097_7FFF, 32'h0000_0000, 32'h0000_EFFF, 1'b1},
        {32'h5A2F_0020, 32'hFFFF_FFF0, 32'h0000_0010, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R7: reset with non-zero inputs clears the outputs.
        in_instr = 32'hDEAD_BEEF;
        in_pc    = 32'h1111_1111;
        @(posedge clk); #1;
        check("R7 reset opcode", {24'h0, out_opcode}, 32'h0);
        check("R7 reset rsel",   {28'h0, out_rsel},   32'h0);
        check("R7 reset addr",   out_addr,            32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table (R1 R2 R3 R4 R5 R6 R8).
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_instr = VEC[i][96:65];
            in_pc    = VEC[i][64:33];
            #1;
            check("R5 index is x",  {28'h0, rf_rd_idx}, {28'h0, VEC[i][84:81]});
            check("R2/R3/R4 request", {31'h0, rf_rd_req}, {31'h0, VEC[i][0]});
            @(posedge clk); #1;
            check("R2/R3/R4/R8 address", out_addr, VEC[i][32:1]);
            check("R1 R6 opcode", {24'h0, out_opcode}, {24'h0, VEC[i][96:89]});
            check("R1 R6 rsel",   {28'h0, out_rsel},   {28'h0, VEC[i][88:85]});
        end

        // R4: the returned data is used, checked through a second register.
        @(negedge clk);
        in_instr = 32'h0002_0000;
        #1;
        check("R4 request x=2", {31'h0, rf_rd_req}, 32'h1);
        @(posedge clk); #1;
        check("R4 address x=2", out_addr, 32'h0000_2000);

        // R7: reset in mid-run clears a loaded value.
        @(negedge clk);
        in_instr = 32'hC3B5_0001;
        @(posedge clk); #1;
        check("R8 address x=5", out_addr, 32'h0000_5001);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R7 midrun addr",   out_addr,            32'h0);
        check("R7 midrun opcode", {24'h0, out_opcode}, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule